// File: doc/BRIEF.md
# Program Fetch Bus Controller

This block sits between an 8-bit CPU core and program storage. It keeps a 16-bit fetch pointer, accepts one fetch request at a time, and returns the code byte together with a one-cycle ready pulse. Each fetch is routed either to the on-chip ROM or to external program memory. The routing depends on a boot strap input and on the ROM size chosen at build time.

On-chip fetches finish in one cycle, and all bus pins stay quiet. An off-chip fetch runs a fixed multiplexed bus sequence. The low port first carries the low address byte while an address-latch strobe pulses, so that an external latch can capture it. The low port then floats. The high port keeps the upper address byte on the pins, and a read strobe gates the external memory onto the low port. The core either steps through code sequentially or redirects the pointer with a jump on the request.

Top module: `pfetch_ctrl`

## Requirements
- R1: While reset is low and after its release, busy_o, ready_o, ale_o, psen_o and lo_oe_o are 0 and hi_port_o is 00H. The first fetch without a jump is from address 0000H.
- R2: When strap_i was low during reset, every fetch uses the external bus cycle, whatever its address.
- R3: When strap_i was high during reset, addresses below ROM_KB*1024 are fetched internally (0000H–0FFFH for ROM_KB=4, 1FFFH for 8, 3FFFH for 16). All higher addresses are fetched externally.
- R4: An internal fetch raises ready_o in the cycle after acceptance, with data_o equal to rom_data_i for rom_addr_o equal to the low address bits. ale_o, psen_o and lo_oe_o stay 0 throughout.
- R5: In the first cycle after an external fetch is accepted, lo_oe_o=1, lo_port_o carries address bits 7:0, ale_o=1 and hi_port_o carries address bits 15:8.
- R6: In the second cycle, ale_o=0 while lo_oe_o stays 1 and both address bytes are unchanged.
- R7: In the third cycle, lo_oe_o=0 and psen_o=1. lo_port_i is sampled at the end of this cycle.
- R8: In the fourth cycle, psen_o=0, ready_o=1 and data_o holds the sampled byte. In the fifth cycle, busy_o=0 and hi_port_o returns to 00H.
- R9: The fetch address is jump_addr_i when jump_i is high with the request, and otherwise the previous fetch address plus one, wrapping from FFFFH to 0000H. fetch_addr_o reports the address of the returned byte.
- R10: strap_i is sampled only while reset is low (and at the first edge after release). Later changes have no effect on routing.
- R11: A request made while busy_o is high is ignored. It produces no ready pulse and does not change the fetch pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_i | input | 1 | Boot strap: 1 enables the on-chip ROM range |
| req_i | input | 1 | Fetch request, taken when busy_o is low |
| jump_i | input | 1 | Use jump_addr_i as the fetch address |
| jump_addr_i | input | 16 | Jump target |
| rom_addr_o | output | ROM_AW (12/13/14) | On-chip ROM address |
| rom_data_i | input | 8 | On-chip ROM read data (combinational) |
| lo_port_o | output | 8 | Low port output: low address byte |
| lo_oe_o | output | 1 | Low port drive enable; 0 means floated |
| lo_port_i | input | 8 | Low port input: external code byte |
| hi_port_o | output | 8 | High port: upper address byte |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_o | output | 1 | External program read strobe, active high |
| busy_o | output | 1 | External bus cycle in progress |
| ready_o | output | 1 | One-cycle pulse: data_o is valid |
| data_o | output | 8 | Fetched code byte |
| fetch_addr_o | output | 16 | Address of the byte in data_o |

## Verification
The bench aims at the internal/external boundary at 0FFFH/1000H. A wrong compare there would send a ROM byte where an external one is due, and the bus would be idle when it should run. It also checks the pointer wrap from FFFFH into on-chip space. A strap change after reset must not reroute fetches; a live strap would turn an external fetch internal. A request injected during a bus cycle must leave no trace. Were it taken, the bench would see an extra ready pulse or a jump in the pointer. Each bus phase is sampled on its own cycle, so a strobe one phase off or a low port still driven during the read is caught.

// File: rtl/pfetch_pkg.sv
package pfetch_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_HOLD,
    XS_READ,
    XS_DONE
  } xstate_e;

  function automatic int rom_aw(input int kb);
    if (kb >= 16) return 14;
    else if (kb >= 8) return 13;
    else return 12;
  endfunction
endpackage

// File: rtl/pfetch_strap.sv
module pfetch_strap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic strap_o
);
  logic lock_q;
  logic strap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else         lock_q <= 1'b1;
  end

  // follows the pin until the first edge after reset release, then frozen
  always_ff @(posedge clk_i) begin
    if (!lock_q) strap_q <= strap_i;
  end

  assign strap_o = strap_q;
endmodule

// File: rtl/pfetch_decode.sv
module pfetch_decode
  import pfetch_pkg::*;
#(
  parameter int ROM_KB = 4
) (
  input  addr_t addr_i,
  input  logic  strap_i,
  output logic  int_o
);
  localparam int AW = rom_aw(ROM_KB);

  logic above;

  generate
    if (AW < ADDR_W) begin : g_split
      assign above = |addr_i[ADDR_W-1:AW];
    end else begin : g_full
      assign above = 1'b0;
    end
  endgenerate

  assign int_o = strap_i & ~above;
endmodule

// File: rtl/pfetch_extbus.sv
module pfetch_extbus
  import pfetch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  addr_t addr_i,
  input  byte_t port_i,
  output byte_t lo_o,
  output logic  lo_oe_o,
  output byte_t hi_o,
  output logic  ale_o,
  output logic  psen_o,
  output logic  busy_o,
  output logic  done_o,
  output byte_t data_o
);
  xstate_e state_q;
  byte_t   lo_q, hi_q, data_q;
  logic    oe_q, ale_q, psen_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      data_q  <= '0;
      oe_q    <= 1'b0;
      ale_q   <= 1'b0;
      psen_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (start_i) begin
            state_q <= XS_ADDR;
            lo_q    <= addr_i[BYTE_W-1:0];
            hi_q    <= addr_i[ADDR_W-1:BYTE_W];
            oe_q    <= 1'b1;
            ale_q   <= 1'b1;
          end
        end
        XS_ADDR: begin
          state_q <= XS_HOLD;
          ale_q   <= 1'b0;
        end
        XS_HOLD: begin
          state_q <= XS_READ;
          oe_q    <= 1'b0;
          psen_q  <= 1'b1;
        end
        XS_READ: begin
          state_q <= XS_DONE;
          psen_q  <= 1'b0;
          data_q  <= port_i;
          done_q  <= 1'b1;
        end
        XS_DONE: begin
          state_q <= XS_IDLE;
          done_q  <= 1'b0;
          hi_q    <= '0;
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign lo_o    = lo_q;
  assign lo_oe_o = oe_q;
  assign hi_o    = hi_q;
  assign ale_o   = ale_q;
  assign psen_o  = psen_q;
  assign busy_o  = (state_q != XS_IDLE);
  assign done_o  = done_q;
  assign data_o  = data_q;
endmodule

// File: rtl/pfetch_ctrl.sv
module pfetch_ctrl
  import pfetch_pkg::*;
#(
  parameter  int ROM_KB = 4,
  localparam int ROM_AW = rom_aw(ROM_KB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic              req_i,
  input  logic              jump_i,
  input  logic [15:0]       jump_addr_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]        rom_data_i,
  output logic [7:0]        lo_port_o,
  output logic              lo_oe_o,
  input  logic [7:0]        lo_port_i,
  output logic [7:0]        hi_port_o,
  output logic              ale_o,
  output logic              psen_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic [7:0]        data_o,
  output logic [15:0]       fetch_addr_o
);
  logic  strap_q;
  logic  use_int, accept, ext_busy, ext_done;
  addr_t pc_q, fa, fetch_addr_q;
  byte_t int_data_q, ext_data;
  logic  int_rdy_q, src_ext_q;

  pfetch_strap u_strap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strap_i (strap_i),
    .strap_o (strap_q)
  );

  assign fa     = jump_i ? jump_addr_i : pc_q;
  assign accept = req_i & ~ext_busy;

  pfetch_decode #(.ROM_KB(ROM_KB)) u_decode (
    .addr_i  (fa),
    .strap_i (strap_q),
    .int_o   (use_int)
  );

  assign rom_addr_o = fa[ROM_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q         <= '0;
      fetch_addr_q <= '0;
      int_data_q   <= '0;
      int_rdy_q    <= 1'b0;
      src_ext_q    <= 1'b0;
    end else begin
      int_rdy_q <= accept & use_int;
      if (accept) begin
        pc_q         <= fa + 1'b1;
        fetch_addr_q <= fa;
        src_ext_q    <= ~use_int;
        if (use_int) int_data_q <= rom_data_i;
      end
    end
  end

  pfetch_extbus u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept & ~use_int),
    .addr_i  (fa),
    .port_i  (lo_port_i),
    .lo_o    (lo_port_o),
    .lo_oe_o (lo_oe_o),
    .hi_o    (hi_port_o),
    .ale_o   (ale_o),
    .psen_o  (psen_o),
    .busy_o  (ext_busy),
    .done_o  (ext_done),
    .data_o  (ext_data)
  );

  assign busy_o       = ext_busy;
  assign ready_o      = int_rdy_q | ext_done;
  assign data_o       = src_ext_q ? ext_data : int_data_q;
  assign fetch_addr_o = fetch_addr_q;
endmodule

// File: rtl/pfetch_ctrl_chk.sv
module pfetch_ctrl_chk #(
  parameter int ROM_KB = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        strap_q,
  input logic        ale_o,
  input logic        psen_o,
  input logic        lo_oe_o,
  input logic [7:0]  lo_port_o,
  input logic [7:0]  hi_port_o,
  input logic        busy_o,
  input logic        ready_o,
  input logic [15:0] fetch_addr_o
);
  localparam logic [16:0] LIMIT = 17'(ROM_KB * 1024);

  a_r5_ale_with_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> lo_oe_o);

  a_r6_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> (!ale_o && lo_oe_o && $stable(lo_port_o) && $stable(hi_port_o)));

  a_r7_float_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psen_o |-> (!lo_oe_o && !ale_o));

  a_r7_hi_stable_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psen_o |-> $stable(hi_port_o));

  a_r8_ready_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_o) |-> (ready_o && busy_o));

  a_r2_strap_low_external: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !strap_q) |-> busy_o);

  a_r3_internal_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !busy_o) |-> (strap_q && ({1'b0, fetch_addr_o} < LIMIT)));

  a_r4_internal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !busy_o) |-> (!ale_o && !psen_o && !lo_oe_o));
endmodule

bind pfetch_ctrl pfetch_ctrl_chk #(.ROM_KB(ROM_KB)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strap_q      (strap_q),
  .ale_o        (ale_o),
  .psen_o       (psen_o),
  .lo_oe_o      (lo_oe_o),
  .lo_port_o    (lo_port_o),
  .hi_port_o    (hi_port_o),
  .busy_o       (busy_o),
  .ready_o      (ready_o),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/pfetch_ctrl_test.sv
`timescale 1ns/1ps
module pfetch_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        req = 1'b0;
  logic        jump = 1'b0;
  logic [15:0] jaddr = '0;
  logic [11:0] rom_addr;
  logic [7:0]  rom_data, lo_out, lo_in, hi_out, data;
  logic        lo_oe, ale, psen, busy, ready;
  logic [15:0] faddr;

  int checks = 0;
  int errors = 0;
  logic [24:0] exp_q[$];
  logic [15:0] exp_pc;
  logic        bench_strap;
  logic [7:0]  latch_q = '0;

  always #2.5 clk = ~clk;

  pfetch_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .req_i(req), .jump_i(jump),
    .jump_addr_i(jaddr), .rom_addr_o(rom_addr), .rom_data_i(rom_data),
    .lo_port_o(lo_out), .lo_oe_o(lo_oe), .lo_port_i(lo_in), .hi_port_o(hi_out),
    .ale_o(ale), .psen_o(psen), .busy_o(busy), .ready_o(ready), .data_o(data),
    .fetch_addr_o(faddr)
  );

  function automatic logic [7:0] rom_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ext_f(input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h33;
  endfunction

  // on-chip ROM and external memory with address latch
  assign rom_data = rom_f({4'h0, rom_addr});
  always @(posedge clk) if (ale) latch_q <= lo_out;
  assign lo_in = psen ? ext_f({hi_out, latch_q}) : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected ready", 1, 0);
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        chk(faddr == e[23:8], "R9 fetch address", faddr, e[23:8]);
        if (e[24]) chk(data == e[7:0] && busy, "R8 external data", data, e[7:0]);
        else       chk(data == e[7:0] && !busy, "R4 internal data", data, e[7:0]);
      end
    end
  end

  task automatic do_reset(input logic s);
    rst_n = 1'b0;
    strap = s;
    req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !ready && !ale && !psen && !lo_oe && hi_out == 8'h00,
        "R1 reset outputs", {busy, ready, ale, psen, lo_oe}, 0);
    rst_n = 1'b1;
    bench_strap = s;
    exp_pc = 16'h0000;
    @(negedge clk);
    chk(!busy && !ready && hi_out == 8'h00, "R1 after release", {busy, ready}, 0);
  endtask

  task automatic fetch(input bit jmp, input logic [15:0] ja, input bit poke);
    logic [15:0] a;
    bit ext;
    a = jmp ? ja : exp_pc;
    ext = !bench_strap || (a >= 16'h1000);
    exp_pc = a + 16'h1;
    exp_q.push_back({ext, a, ext ? ext_f(a) : rom_f(a)});
    @(negedge clk);
    req = 1'b1; jump = jmp; jaddr = ja;
    @(negedge clk);
    req = 1'b0; jump = 1'b0;
    if (ext) begin
      chk(lo_oe && ale && lo_out == a[7:0] && hi_out == a[15:8] && busy,
          "R5 address phase", {lo_oe, ale, lo_out, hi_out}, {2'b11, a});
      @(negedge clk);
      chk(lo_oe && !ale && !psen && lo_out == a[7:0] && hi_out == a[15:8],
          "R6 hold phase", {lo_oe, ale, lo_out}, {2'b10, a[7:0]});
      if (poke) begin
        req = 1'b1; jump = 1'b1; jaddr = 16'h0ABC;
      end
      @(negedge clk);
      req = 1'b0; jump = 1'b0;
      chk(!lo_oe && psen && !ale && hi_out == a[15:8],
          "R7 read phase", {lo_oe, psen, ale}, 3'b010);
      @(negedge clk);
      chk(!psen && ready, "R8 ready phase", {psen, ready}, 2'b01);
      @(negedge clk);
      chk(!busy && !ready && hi_out == 8'h00, "R8 back to idle", {busy, ready, hi_out}, 0);
    end else begin
      chk(ready && !ale && !psen && !lo_oe && !busy,
          "R4 quiet internal", {ready, ale, psen, lo_oe, busy}, 5'b10000);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // strap low: all external (R2), first fetch at 0000H (R1)
    do_reset(1'b0);
    fetch(1'b0, 16'h0, 1'b0);
    fetch(1'b0, 16'h0, 1'b0);
    strap = 1'b1;                       // R10: late strap change ignored
    fetch(1'b0, 16'h0, 1'b0);
    fetch(1'b1, 16'h0100, 1'b0);        // R2: low address still external
    fetch(1'b1, 16'h8123, 1'b1);        // R11: request during busy
    fetch(1'b0, 16'h0, 1'b0);           // R11: pointer continues at 8124H
    repeat (3) @(negedge clk);

    // strap high: internal range (R3)
    do_reset(1'b1);
    fetch(1'b0, 16'h0, 1'b0);
    fetch(1'b0, 16'h0, 1'b0);
    fetch(1'b1, 16'h0FFF, 1'b0);        // R3 top of internal range
    fetch(1'b0, 16'h0, 1'b0);           // R3 1000H goes external
    fetch(1'b1, 16'hFFFF, 1'b0);
    fetch(1'b0, 16'h0, 1'b0);           // R9 wrap to 0000H, internal
    fetch(1'b1, 16'h5555, 1'b0);
    strap = 1'b0;                       // R10: change ignored
    fetch(1'b1, 16'h0ABC, 1'b0);
    fetch(1'b0, 16'h0, 1'b0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all results returned", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule